// File: doc/BRIEF.md
# Serial Receiver with Four-Character Buffer

This block receives asynchronous serial characters on a single line and queues them for a processor. A free-running 16x oversampling strobe (`sample_en`, one clock wide) sets the bit timing; the baud-rate source, the transmitter and any bus decoding are outside the block. Each character is framed by a low start bit and one or more high stop bits, carries 5 to 8 data bits least significant first, and may be followed by a parity bit or by an address/data marker bit.

Every completed character is stored together with its error flags: parity error, framing error, break and address marker. Storage is three holding slots plus the shift stage itself, so four characters can be waiting before data is lost. The processor reads the oldest entry through a combinational read port and pops it with a one-cycle `rd_en`. Status outputs report when data is waiting, when the holding slots are full and when a character has been dropped. An optional flow-control output tells the far end to pause while the holding slots are full.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset `rdy`, `full` and `ovr` are 0 and `rts_n` is 0.
- R2: Bits are taken least significant first. The number of data bits is 5 plus `char_len`, and unused upper bits of `rd_data` read as 0. The start bit is sampled again 8 strobes after the falling edge is seen, and each later bit is sampled 16 strobes after the previous one.
- R3: `par_mode` selects the parity rule. 00 means even (the data bits and the parity bit hold an even number of ones). 01 means odd. 10 means the bit must equal `par_force`. 11 means no parity bit. A mismatch sets `rd_par_err` on that entry.
- R4: A stop bit sampled low sets `rd_frm_err` on that entry.
- R5: A start bit that is high again at the middle sample is rejected, and nothing is stored.
- R6: Up to four characters are held: three in the holding slots and one in the shift stage. They are read back in arrival order, and a pop moves the waiting shift-stage character into the holding slots.
- R7: `rdy` is 1 whenever at least one holding slot is occupied. `full` is 1 when all three are occupied. `rdy` drops in the cycle after the pop of the last entry.
- R8: A character that completes while four are already held is discarded and sets `ovr`. `ovr` stays set until `clr_ovr` is pulsed.
- R9: With `flow_en`=1, `rts_n` is high exactly while `full` is 1. With `flow_en`=0, `rts_n` stays low.
- R10: A frame whose data bits, extra bit and stop bit are all low is stored as a break entry (`rd_brk`=1, `rd_frm_err`=1, `rd_par_err`=0, data 0). Nothing further is stored until the line has been seen high. A break that begins inside a character first yields that character with a framing error and then the break entry.
- R11: With `wake_en`=1 the extra bit follows the data whatever `par_mode` says. It is reported on `rd_addr` (1 = address character) and is never checked as parity.
- R12: `rd_en` while `rdy` is 0 has no effect on the stored entries or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en | input | 1 | 16x oversampling strobe |
| rxd | input | 1 | Serial line, idle high |
| char_len | input | 2 | Data bits minus 5 |
| par_mode | input | 2 | 00 even, 01 odd, 10 forced, 11 none |
| par_force | input | 1 | Expected bit value in forced mode |
| wake_en | input | 1 | Extra bit is an address marker |
| flow_en | input | 1 | Enable automatic flow control |
| rd_en | input | 1 | Pop the oldest entry |
| clr_ovr | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Oldest entry's data |
| rd_par_err | output | 1 | Oldest entry's parity error |
| rd_frm_err | output | 1 | Oldest entry's framing error |
| rd_brk | output | 1 | Oldest entry is a break |
| rd_addr | output | 1 | Oldest entry is an address character |
| rdy | output | 1 | At least one entry waiting |
| full | output | 1 | All holding slots occupied |
| ovr | output | 1 | A character was dropped |
| rts_n | output | 1 | Request to send, active low |

## Verification
Characters with alternating bit patterns at the longest and shortest lengths show whether bit order and length masking are right. Frames with a good and a bad parity bit in each parity mode tell the parity rules apart. A burst of five characters with no reads separates the fourth-stage hold from a genuine overrun and shows the flow-control output following `full`. A short low glitch, a low stop bit, and a line that drops low in the middle of a character and stays there distinguish a rejected start, a framing error and a break; marker-bit frames in wake mode confirm that the extra bit is not treated as parity.

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int HOLD_DEPTH = 3,
  parameter int OVS        = 16,
  parameter int MAX_BITS   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic                rxd,
  input  logic [1:0]          char_len,
  input  logic [1:0]          par_mode,
  input  logic                par_force,
  input  logic                wake_en,
  input  logic                flow_en,
  input  logic                rd_en,
  input  logic                clr_ovr,
  output logic [MAX_BITS-1:0] rd_data,
  output logic                rd_par_err,
  output logic                rd_frm_err,
  output logic                rd_brk,
  output logic                rd_addr,
  output logic                rdy,
  output logic                full,
  output logic                ovr,
  output logic                rts_n
);

  localparam int PW = (HOLD_DEPTH > 1) ? $clog2(HOLD_DEPTH) : 1;
  localparam int NW = $clog2(HOLD_DEPTH + 1);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(MAX_BITS);
  localparam int EW = MAX_BITS + 4;
  localparam logic [CW-1:0] T_MID = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] T_END = CW'(OVS - 1);
  localparam logic [PW-1:0] P_LAST = PW'(HOLD_DEPTH - 1);
  localparam logic [NW-1:0] N_FULL = NW'(HOLD_DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_EXTRA, S_STOP, S_BRKW} rx_st_t;

  rx_st_t               st;
  logic [CW-1:0]        tcnt;
  logic [BW-1:0]        bitn;
  logic [MAX_BITS-1:0]  shreg;
  logic                 xbit;

  logic                 has_x, par_err, stop_smp, brk_now, push, pop;
  logic [BW-1:0]        last_bit;
  logic [EW-1:0]        new_e;

  logic [EW-1:0]        mem [HOLD_DEPTH];
  logic [PW-1:0]        wp, rp;
  logic [NW-1:0]        cnt;
  logic [EW-1:0]        stg;
  logic                 stg_vld;
  logic                 wr_mem, to_stg, ovr_set;
  logic [EW-1:0]        wr_val;

  assign has_x    = wake_en | (par_mode != 2'b11);
  assign last_bit = BW'(char_len) + BW'(4);
  assign stop_smp = sample_en && (st == S_STOP) && (tcnt == T_END);
  assign brk_now  = !rxd && (shreg == '0) && !(has_x && xbit);
  assign push     = stop_smp;

  always_comb begin
    par_err = 1'b0;
    if (!wake_en) begin
      case (par_mode)
        2'b00:   par_err = (^shreg) ^ xbit;
        2'b01:   par_err = ~((^shreg) ^ xbit);
        2'b10:   par_err = xbit ^ par_force;
        default: par_err = 1'b0;
      endcase
    end
  end

  assign new_e = {brk_now, wake_en & xbit, ~rxd, par_err & ~brk_now, shreg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      tcnt  <= '0;
      bitn  <= '0;
      shreg <= '0;
      xbit  <= 1'b0;
    end else if (sample_en) begin
      case (st)
        S_IDLE: if (!rxd) begin
          st   <= S_START;
          tcnt <= '0;
        end
        S_START: if (tcnt == T_MID) begin
          tcnt  <= '0;
          bitn  <= '0;
          shreg <= '0;
          xbit  <= 1'b0;
          st    <= rxd ? S_IDLE : S_DATA;
        end else tcnt <= tcnt + 1'b1;
        S_DATA: if (tcnt == T_END) begin
          tcnt        <= '0;
          shreg[bitn] <= rxd;
          if (bitn == last_bit) st <= has_x ? S_EXTRA : S_STOP;
          else                  bitn <= bitn + 1'b1;
        end else tcnt <= tcnt + 1'b1;
        S_EXTRA: if (tcnt == T_END) begin
          tcnt <= '0;
          xbit <= rxd;
          st   <= S_STOP;
        end else tcnt <= tcnt + 1'b1;
        S_STOP: if (tcnt == T_END) begin
          tcnt <= '0;
          st   <= brk_now ? S_BRKW : S_IDLE;
        end else tcnt <= tcnt + 1'b1;
        S_BRKW: if (rxd) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == P_LAST) ? '0 : p + 1'b1;
  endfunction

  assign pop     = rd_en && (cnt != '0);
  assign wr_mem  = stg_vld ? pop : (push && (pop || cnt != N_FULL));
  assign wr_val  = stg_vld ? stg : new_e;
  assign to_stg  = push && (stg_vld ? pop : (!pop && cnt == N_FULL));
  assign ovr_set = push && stg_vld && !pop;

  always_ff @(posedge clk) begin
    if (wr_mem) mem[wp] <= wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      stg     <= '0;
      stg_vld <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      if (wr_mem) wp <= nxt(wp);
      if (pop)    rp <= nxt(rp);
      cnt <= cnt + NW'(wr_mem) - NW'(pop);
      if (to_stg) begin
        stg     <= new_e;
        stg_vld <= 1'b1;
      end else if (stg_vld && pop) begin
        stg_vld <= 1'b0;
      end
      ovr <= ovr_set | (ovr & ~clr_ovr);
    end
  end

  assign {rd_brk, rd_addr, rd_frm_err, rd_par_err, rd_data} = mem[rp];
  assign rdy   = (cnt != '0);
  assign full  = (cnt == N_FULL);
  assign rts_n = flow_en & full;

endmodule

// File: rtl/serial_rx_fifo_chk.sv
module serial_rx_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic sample_en,
  input logic rd_en,
  input logic clr_ovr,
  input logic flow_en,
  input logic rdy,
  input logic full,
  input logic ovr,
  input logic rts_n
);

  p_full_has_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> rdy);

  p_hold_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdy && !rd_en |=> rdy);

  p_no_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full && !rd_en |=> full);

  p_empty_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy && !sample_en |=> !rdy);

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !clr_ovr |=> ovr);

  p_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(full));

  p_rts_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flow_en && full && !rd_en |=> (rts_n || !flow_en));

endmodule

bind serial_rx_fifo serial_rx_fifo_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rd_en(rd_en),
  .clr_ovr(clr_ovr), .flow_en(flow_en), .rdy(rdy), .full(full),
  .ovr(ovr), .rts_n(rts_n)
);

// File: tb/test_serial_rx_fifo.sv
module test_serial_rx_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 1'b0;
  logic rxd = 1'b1;
  logic [1:0] char_len = 2'd3;
  logic [1:0] par_mode = 2'b11;
  logic par_force = 1'b0;
  logic wake_en = 1'b0;
  logic flow_en = 1'b0;
  logic rd_en = 1'b0;
  logic clr_ovr = 1'b0;
  logic [7:0] rd_data;
  logic rd_par_err, rd_frm_err, rd_brk, rd_addr, rdy, full, ovr, rts_n;

  int tests = 0;
  int fails = 0;
  int tick_div = 0;
  bit cmp_on = 1'b0;
  bit m_ovr = 1'b0;
  logic [11:0] q[$];

  always #10 clk = ~clk;

  serial_rx_fifo i_serial_rx_fifo (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rxd(rxd),
    .char_len(char_len), .par_mode(par_mode), .par_force(par_force),
    .wake_en(wake_en), .flow_en(flow_en), .rd_en(rd_en), .clr_ovr(clr_ovr),
    .rd_data(rd_data), .rd_par_err(rd_par_err), .rd_frm_err(rd_frm_err),
    .rd_brk(rd_brk), .rd_addr(rd_addr), .rdy(rdy), .full(full),
    .ovr(ovr), .rts_n(rts_n)
  );

  always @(negedge clk) begin
    tick_div = (tick_div + 1) % 4;
    sample_en <= (tick_div == 0);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check(rdy == (q.size() > 0), "R7 rdy", int'(rdy), int'(q.size() > 0));
      check(full == (q.size() >= 3), "R7 full", int'(full), int'(q.size() >= 3));
      check(ovr == m_ovr, "R8 ovr", int'(ovr), int'(m_ovr));
      check(rts_n == (flow_en && q.size() >= 3), "R9 rts_n", int'(rts_n),
            int'(flow_en && q.size() >= 3));
      if (q.size() > 0)
        check({rd_brk, rd_addr, rd_frm_err, rd_par_err, rd_data} == q[0], "R6 head entry",
              int'({rd_brk, rd_addr, rd_frm_err, rd_par_err, rd_data}), int'(q[0]));
    end
  end

  function automatic logic [11:0] exp_entry(input logic [7:0] d, input bit hx, input bit x,
                                             input bit stop);
    bit ones = ^d;
    bit brk = (d == 8'h00) && !stop && !(hx && x);
    bit per = 1'b0;
    if (!wake_en && hx) begin
      if (par_mode == 2'b00) per = ones ^ x;
      else if (par_mode == 2'b01) per = !(ones ^ x);
      else if (par_mode == 2'b10) per = (x != par_force);
    end
    if (brk) per = 1'b0;
    return {brk, wake_en & x, !stop, per, d};
  endfunction

  function automatic void model_push(input logic [11:0] e);
    if (q.size() < 4) q.push_back(e);
    else m_ovr = 1'b1;
  endfunction

  task automatic wait_tick();
    do @(posedge clk); while (!sample_en);
  endtask

  task automatic drive_bit(input bit v, input int n);
    @(negedge clk) rxd = v;
    repeat (n) wait_tick();
  endtask

  task automatic send_frame(input logic [7:0] d, input bit x, input bit stop);
    int nb = 5 + int'(char_len);
    bit hx = wake_en || (par_mode != 2'b11);
    logic [7:0] dm = d & 8'((1 << nb) - 1);
    drive_bit(1'b0, 16);
    for (int i = 0; i < nb; i++) drive_bit(dm[i], 16);
    if (hx) drive_bit(x, 16);
    @(negedge clk) rxd = stop;
    repeat (9) wait_tick();
    #1 model_push(exp_entry(dm, hx, x, stop));
    repeat (7) wait_tick();
    drive_bit(1'b1, 4);
  endtask

  task automatic read_one(input string tag, input logic [11:0] exp);
    logic [11:0] got;
    @(negedge clk);
    got = {rd_brk, rd_addr, rd_frm_err, rd_par_err, rd_data};
    check(got == exp, tag, int'(got), int'(exp));
    rd_en = 1'b1;
    @(posedge clk);
    #1 if (q.size() > 0) void'(q.pop_front());
    @(negedge clk) rd_en = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr_ovr = 1'b1;
    @(posedge clk);
    #1 m_ovr = 1'b0;
    @(negedge clk) clr_ovr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(rdy == 0 && full == 0 && ovr == 0 && rts_n == 0, "R1 reset flags",
          int'({rdy, full, ovr, rts_n}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rdy == 0 && full == 0 && ovr == 0 && rts_n == 0, "R1 after release",
          int'({rdy, full, ovr, rts_n}), 0);
    cmp_on = 1'b1;
    drive_bit(1'b1, 4);

    // R2: 8 data bits, LSB first, no parity
    send_frame(8'hA5, 1'b0, 1'b1);
    read_one("R2 8-bit A5", 12'h0A5);
    // R2: 5 data bits, upper bits masked; R3 even parity correct
    char_len = 2'd0; par_mode = 2'b00;
    send_frame(8'hF5, 1'b1, 1'b1);
    read_one("R2 R3 5-bit even ok", 12'h015);
    // R3: odd parity wrong bit
    char_len = 2'd2; par_mode = 2'b01;
    send_frame(8'h41, 1'b0, 1'b1);
    read_one("R3 odd parity error", 12'h141);
    // R3: forced parity mismatch and match
    char_len = 2'd1; par_mode = 2'b10; par_force = 1'b1;
    send_frame(8'h2A, 1'b0, 1'b1);
    read_one("R3 forced mismatch", 12'h12A);
    send_frame(8'h2A, 1'b1, 1'b1);
    read_one("R3 forced match", 12'h02A);

    // R4: framing error
    char_len = 2'd3; par_mode = 2'b11;
    send_frame(8'h3C, 1'b0, 1'b0);
    drive_bit(1'b1, 24);
    check(q.size() == 1, "R4 single entry after low stop", q.size(), 1);
    read_one("R4 framing error", 12'h23C);

    // R5: false start
    drive_bit(1'b0, 4);
    drive_bit(1'b1, 40);
    check(rdy == 1'b0, "R5 glitch not stored", int'(rdy), 0);
    send_frame(8'h5A, 1'b0, 1'b1);
    read_one("R5 next frame intact", 12'h05A);

    // R12: read while empty
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    check(rdy == 0 && ovr == 0, "R12 empty read no effect", int'({rdy, ovr}), 0);
    send_frame(8'h77, 1'b0, 1'b1);
    read_one("R12 data after empty read", 12'h077);

    // R6 R8 R9: burst of five without reads
    flow_en = 1'b1;
    send_frame(8'h11, 1'b0, 1'b1);
    send_frame(8'h22, 1'b0, 1'b1);
    send_frame(8'h33, 1'b0, 1'b1);
    check(rts_n == 1'b1 && full == 1'b1, "R9 rts high on full", int'({rts_n, full}), 3);
    send_frame(8'h44, 1'b0, 1'b1);
    check(ovr == 1'b0, "R6 fourth char held", int'(ovr), 0);
    @(negedge clk) flow_en = 1'b0;
    @(negedge clk);
    check(rts_n == 1'b0, "R9 rts low when disabled", int'(rts_n), 0);
    flow_en = 1'b1;
    send_frame(8'h55, 1'b0, 1'b1);
    check(ovr == 1'b1, "R8 fifth char overrun", int'(ovr), 1);
    read_one("R6 order 1", 12'h011);
    check(full == 1'b1, "R6 shift stage refills", int'(full), 1);
    read_one("R6 order 2", 12'h022);
    read_one("R6 order 3", 12'h033);
    read_one("R6 order 4", 12'h044);
    @(negedge clk);
    check(rdy == 1'b0, "R7 rdy clears after last pop", int'(rdy), 0);
    check(ovr == 1'b1, "R8 overrun sticky", int'(ovr), 1);
    pulse_clr();
    @(negedge clk);
    check(ovr == 1'b0, "R8 cleared by command", int'(ovr), 0);
    flow_en = 1'b0;

    // R10: break beginning mid-character
    drive_bit(1'b0, 16);
    for (int i = 0; i < 4; i++) drive_bit(1'b1, 16);
    @(negedge clk) rxd = 1'b0;
    repeat (64 + 9) wait_tick();
    #1 model_push(12'h20F);
    wait_tick();
    repeat (152) wait_tick();
    #1 model_push(12'hA00);
    repeat (60) wait_tick();
    check(q.size() == 2, "R10 nothing more while low", q.size(), 2);
    drive_bit(1'b1, 8);
    read_one("R10 partial char framing error", 12'h20F);
    read_one("R10 break entry", 12'hA00);
    send_frame(8'hC3, 1'b0, 1'b1);
    read_one("R10 recovery after mark", 12'h0C3);

    // R11: wake mode address marker
    wake_en = 1'b1;
    send_frame(8'h81, 1'b1, 1'b1);
    read_one("R11 address char", 12'h481);
    par_mode = 2'b00;
    send_frame(8'h01, 1'b0, 1'b1);
    read_one("R11 data char no parity check", 12'h001);
    wake_en = 1'b0; par_mode = 2'b11;

    drive_bit(1'b1, 8);
    cmp_on = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule